// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is a bus master for a two-wire serial bus. Software drives it through a small byte-wide register port and moves one byte per command. Setting the master bit produces a START. Writing the data register in transmit mode shifts a byte out and captures the slave's acknowledge. In receive mode, reading the data register returns the byte just received and clocks in the next one. The first such read after the address phase returns nothing useful. Clearing the master bit produces a STOP. Setting the repeat bit produces a repeated START.

Both bus lines are open-drain. The block only ever pulls them low, through `scl_oe` and `sda_oe`. The line levels come back on `scl_i` and `sda_i` through a two-stage synchronizer and a sampling filter. A register sets the filter's sampling interval. The SCL half period comes from the divider register. When SDA reads low while the block is releasing it, the block has lost arbitration. It then leaves the bus at once and flags the loss. An interrupt line reports each completed byte.

Top module: `i2c_byte_master`

## Requirements
- R1: The register offsets are 0x04 divider, 0x08 control, 0x0C status, 0x10 data and 0x14 filter rate. Reset clears every register, and the divider, filter rate and control registers read back what was written. The control bits are enable 0x80, interrupt enable 0x40, master 0x20, transmit 0x10, send-NACK 0x08 and repeat 0x04.
- R2: Setting the master bit while enabled pulls SDA low while SCL is high, then holds SCL low. After the START the bus-busy status bit (0x20) reads 1.
- R3: A data write in transmit mode sends the byte MSB first on eight clocks and releases SDA on the ninth. The level sampled on the ninth clock lands in status bit 0x01 (1 means NACK).
- R4: Transfer-complete (status 0x80) is 0 while a byte runs. After the ninth clock, transfer-complete and interrupt-pending (0x02) are both 1 and SCL is held low.
- R5: In receive mode, a data read returns the previous byte and starts the next one. On its ninth clock the block drives SDA low (ACK) when send-NACK is 0 and leaves SDA released (NACK) when send-NACK is 1.
- R6: A data read while the transmit bit is 1 clocks no byte, so SCL stays low and interrupt-pending stays 0.
- R7: Setting the repeat bit while master produces a new START without any STOP in between, and the repeat bit then reads back as 0.
- R8: Clearing the master bit while master produces a STOP: SDA rises while SCL is high, both lines end released, and bus-busy returns to 0.
- R9: Writing the status register clears arbitration-lost (0x10) and interrupt-pending wherever a 0 is written. A flag set by the hardware in the same cycle stays set.
- R10: `irq` equals interrupt-pending AND interrupt enable on every cycle.
- R11: If SDA reads low on a clock where the block sends a 1, the block sets arbitration-lost and interrupt-pending, clears the master bit and releases both lines without a STOP.
- R12: Inside a byte, each SCL low phase lasts the divider value plus 3 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on data) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Two things can land on the same clock edge: a software write of zero to the status register, and the hardware setting interrupt-pending as a byte finishes. The bench repeats that clearing write on every cycle of a running byte, so one of those writes must coincide with the completion edge. It stops writing at the first cycle in which transfer-complete reads 1, and interrupt-pending must read 1 at that moment. At every clock the bench also compares `irq` with its own model of the enable bit and the status port.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = DIV_W + 1;
  localparam logic [4:0] A_DIV = 5'h04, A_CTL = 5'h08, A_STS = 5'h0C,
                         A_DAT = 5'h10, A_FLT = 5'h14;
  localparam int B_EN = 7, B_IE = 6, B_MS = 5, B_TX = 4, B_NK = 3, B_RS = 2;

  typedef enum logic [3:0] {IDLE, ST_A, HOLD, BIT_L, BIT_H,
                            SP_A, SP_B, SP_C, RS_A, RS_B} st_t;

  st_t st;
  logic [DIV_W-1:0] div_q;
  logic [7:0] flt_q, ctl, dat, sh, scnt;
  logic mcf, mal, mif, rxak, busy, tx_q, tx_pend, rd_pend;
  logic [3:0] bitn;
  logic [CW-1:0] cnt;
  logic [1:0] s1, s2, smp, lf, lf_q;

  wire wr_div = reg_wr && reg_addr == A_DIV;
  wire wr_ctl = reg_wr && reg_addr == A_CTL;
  wire wr_sts = reg_wr && reg_addr == A_STS;
  wire wr_dat = reg_wr && reg_addr == A_DAT;
  wire wr_flt = reg_wr && reg_addr == A_FLT;
  wire rd_dat = reg_rd && reg_addr == A_DAT;

  wire [CW-1:0] half = CW'(div_q) + CW'(3);
  wire scl_f = lf[1];
  wire sda_f = lf[0];
  wire cnt_run = !(st inside {BIT_H, SP_B, RS_B}) || scl_f;
  wire done = cnt_run && (cnt == half - CW'(1));
  wire master_on = ctl[B_EN] && ctl[B_MS];

  assign irq = mif & ctl[B_IE];

  always_comb begin
    case (reg_addr)
      A_DIV:   reg_rdata = 8'(div_q);
      A_CTL:   reg_rdata = ctl;
      A_STS:   reg_rdata = {mcf, 1'b0, busy, mal, 2'b00, mif, rxak};
      A_DAT:   reg_rdata = dat;
      A_FLT:   reg_rdata = flt_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  // input synchronizer and sampling filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; smp <= 2'b11; lf <= 2'b11; lf_q <= 2'b11;
      scnt <= '0; busy <= 1'b0;
    end else begin
      s1 <= {scl_i, sda_i};
      s2 <= s1;
      lf_q <= lf;
      if (scnt >= flt_q) begin
        scnt <= '0;
        smp <= s2;
        if (s2[1] == smp[1]) lf[1] <= s2[1];
        if (s2[0] == smp[0]) lf[0] <= s2[0];
      end else begin
        scnt <= scnt + 8'd1;
      end
      if (lf_q[1] && lf[1] && lf_q[0] && !lf[0]) busy <= 1'b1;
      else if (lf_q[1] && lf[1] && !lf_q[0] && lf[0]) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; div_q <= '0; flt_q <= '0; ctl <= '0; dat <= '0; sh <= '0;
      mcf <= 1'b0; mal <= 1'b0; mif <= 1'b0; rxak <= 1'b0;
      tx_q <= 1'b0; tx_pend <= 1'b0; rd_pend <= 1'b0;
      bitn <= '0; cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (wr_div) div_q <= DIV_W'(reg_wdata);
      if (wr_flt) flt_q <= reg_wdata;
      if (wr_ctl) ctl <= reg_wdata;
      if (wr_dat) begin
        dat <= reg_wdata;
        if (master_on) tx_pend <= 1'b1;
      end
      if (rd_dat && master_on && !ctl[B_TX]) rd_pend <= 1'b1;
      if (wr_sts) begin
        mal <= mal & reg_wdata[4];
        mif <= mif & reg_wdata[1];
      end
      if (cnt_run) cnt <= cnt + CW'(1);

      case (st)
        IDLE: if (master_on) begin
          if (busy) begin
            mal <= 1'b1; mif <= 1'b1; ctl[B_MS] <= 1'b0;
          end else begin
            st <= ST_A; sda_oe <= 1'b1; cnt <= '0;
          end
        end
        ST_A: if (done) begin scl_oe <= 1'b1; st <= HOLD; end
        HOLD: begin
          if (!ctl[B_MS]) begin
            st <= SP_A; sda_oe <= 1'b1; cnt <= '0;
            tx_pend <= 1'b0; rd_pend <= 1'b0;
          end else if (ctl[B_RS]) begin
            st <= RS_A; sda_oe <= 1'b0; cnt <= '0; ctl[B_RS] <= 1'b0;
          end else if (tx_pend && ctl[B_TX]) begin
            st <= BIT_L; bitn <= '0; cnt <= '0; mcf <= 1'b0;
            sh <= dat; tx_q <= 1'b1; tx_pend <= 1'b0;
          end else if (rd_pend && !ctl[B_TX]) begin
            st <= BIT_L; bitn <= '0; cnt <= '0; mcf <= 1'b0;
            tx_q <= 1'b0; rd_pend <= 1'b0;
          end
        end
        BIT_L: begin
          if (cnt == CW'(1))
            sda_oe <= tx_q ? (bitn < 4'd8 && !sh[7]) : (bitn == 4'd8 && !ctl[B_NK]);
          if (done) begin scl_oe <= 1'b0; st <= BIT_H; cnt <= '0; end
        end
        BIT_H: if (done) begin
          if (tx_q && bitn < 4'd8 && !sda_oe && !sda_f) begin
            mal <= 1'b1; mif <= 1'b1; ctl[B_MS] <= 1'b0;
            scl_oe <= 1'b0; sda_oe <= 1'b0; st <= IDLE;
            tx_pend <= 1'b0; rd_pend <= 1'b0;
          end else begin
            scl_oe <= 1'b1; cnt <= '0; bitn <= bitn + 4'd1;
            if (bitn < 4'd8) sh <= {sh[6:0], sda_f};
            else if (tx_q) rxak <= sda_f;
            if (bitn == 4'd8) begin
              st <= HOLD; mcf <= 1'b1; mif <= 1'b1;
              if (!tx_q) dat <= sh;
            end else begin
              st <= BIT_L;
            end
          end
        end
        SP_A: if (done) begin scl_oe <= 1'b0; st <= SP_B; cnt <= '0; end
        SP_B: if (done) begin sda_oe <= 1'b0; st <= SP_C; cnt <= '0; end
        SP_C: if (done) st <= IDLE;
        RS_A: if (done) begin scl_oe <= 1'b0; st <= RS_B; cnt <= '0; end
        RS_B: if (done) begin sda_oe <= 1'b1; st <= ST_A; cnt <= '0; end
        default: st <= IDLE;
      endcase

      if (wr_ctl && !reg_wdata[B_EN]) begin
        st <= IDLE; scl_oe <= 1'b0; sda_oe <= 1'b0;
        tx_pend <= 1'b0; rd_pend <= 1'b0;
      end
    end
  end

  // R11: a lost arbitration leaves the bus and drops master mode
  assert_arb_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mal) |-> (!ctl[B_MS] && !scl_oe && !sda_oe)) else $error("R11 arbitration release");

  // R4: completion arrives with SCL held low and the interrupt flag set
  assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mcf) |-> (mif && st == HOLD && scl_oe)) else $error("R4 completion");

  // R4: no completion flag while bits are moving
  assert_mcf_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BIT_L || st == BIT_H) |-> !mcf) else $error("R4 mcf during byte");

  // R3: SDA must not move while SCL is released inside a byte
  assert_sda_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BIT_H && $past(st) == BIT_H) |-> $stable(sda_oe)) else $error("R3 sda moved");

  // R5: acknowledge driven on the ninth receive clock follows the send-NACK bit
  assert_rx_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BIT_H && !tx_q && bitn == 4'd8) |-> (sda_oe == !ctl[B_NK])) else $error("R5 ack drive");
endmodule

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] reg_addr = 5'h0C;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic slv_sda = 1'b0, rival = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !sda_oe && !slv_sda && !rival;

  i2c_byte_master dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #10 clk = ~clk;

  int vec = 0, bad = 0;
  logic ie_m = 1'b0;

  // behavioural slave
  int scnt = -1, starts = 0, stops = 0, scl_rises = 0;
  logic [7:0] ssh, cur;
  logic first_b, tx_mode, mack, ack_en = 1'b1;
  logic [7:0] rxq[$];
  logic [7:0] rdq[$];

  always @(negedge sda_w) if (scl_w) begin
    starts++; scnt = 0; first_b = 1'b1; tx_mode = 1'b0; slv_sda = 1'b0;
  end
  always @(posedge sda_w) if (scl_w) begin
    stops++; scnt = -1; slv_sda = 1'b0;
  end
  always @(posedge scl_w) begin
    scl_rises++;
    if (scnt >= 0) begin
      if (scnt < 8) ssh = {ssh[6:0], sda_w};
      else if (tx_mode) mack = sda_w;
      scnt++;
    end
  end
  always @(negedge scl_w) if (scnt >= 0) begin
    if (scnt == 9) begin
      scnt = 0; slv_sda = 1'b0;
      if (tx_mode) begin
        if (mack) scnt = -1;
      end else begin
        rxq.push_back(ssh);
        if (first_b) begin first_b = 1'b0; tx_mode = ssh[0]; end
      end
    end
    if (scnt >= 0) begin
      if (tx_mode && scnt == 0) cur = (rdq.size() > 0) ? rdq.pop_front() : 8'hFF;
      if (tx_mode && scnt < 8) slv_sda = !cur[7 - scnt];
      else if (!tx_mode && scnt == 8) slv_sda = ack_en;
      else slv_sda = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison of the interrupt line against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && reg_addr == 5'h0C && !reg_rd) begin
      vec++;
      if (irq !== (ie_m & reg_rdata[1])) begin
        bad++;
        $display("FAIL R10 irq actual=%0b expected=%0b", irq, ie_m & reg_rdata[1]);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 5'h0C;
    if (a == 5'h08) ie_m = d[6];
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 5'h0C;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (reg_rdata[1]) return;
    end
    chk("R4 byte never completed", 0, 1);
  endtask

  task automatic measure_low(output int len);
    @(negedge scl_w);
    len = 0;
    @(negedge clk);
    while (!scl_w) begin len++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; vec++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int len, s0, p0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 4; a <= 20; a += 4) begin
      rd(5'(a), v);
      chk($sformatf("R1 reset reg %0h", a), v, 0);
    end
    chk("R10 irq after reset", irq, 0);
    wr(5'h04, 8'h07); wr(5'h14, 8'h00);
    rd(5'h04, v); chk("R1 divider readback", v, 8'h07);
    wr(5'h14, 8'h03); rd(5'h14, v); chk("R1 filter readback", v, 8'h03);
    wr(5'h14, 8'h00);
    wr(5'h08, 8'hC2); rd(5'h08, v); chk("R1 control readback", v, 8'hC2);

    // R2 START
    s0 = starts;
    wr(5'h08, 8'hF0);
    repeat (40) @(negedge clk);
    chk("R2 start seen", starts - s0, 1);
    chk("R2 scl held low", scl_w, 0);
    rd(5'h0C, v); chk("R2 bus busy", v[5], 1);

    // R3/R4 transmit with ACK
    ack_en = 1'b1;
    wr(5'h10, 8'hA4);
    repeat (20) @(negedge clk);
    rd(5'h0C, v); chk("R4 mcf low during byte", v[7], 0);
    wait_done();
    chk("R3 byte on bus", rxq[$], 8'hA4);
    rd(5'h0C, v);
    chk("R3 ack captured", v[0], 0);
    chk("R4 mcf set", v[7], 1);
    chk("R4 mif set", v[1], 1);
    chk("R10 irq raised", irq, 1);
    chk("R4 scl held after byte", scl_w, 0);
    wr(5'h0C, 8'h00);
    rd(5'h0C, v); chk("R9 mif cleared", v[1], 0);
    chk("R10 irq cleared", irq, 0);

    // R3 NACK, R12 low phase at divider 7
    ack_en = 1'b0;
    wr(5'h10, 8'h3C);
    measure_low(len);
    chk("R12 low phase div7", len, 10);
    wait_done();
    chk("R3 second byte", rxq[$], 8'h3C);
    rd(5'h0C, v); chk("R3 nack captured", v[0], 1);
    wr(5'h0C, 8'h00);

    // R7 repeated START then read address
    ack_en = 1'b1;
    rdq.push_back(8'h5A); rdq.push_back(8'hC3);
    s0 = starts; p0 = stops;
    wr(5'h08, 8'hF4);
    wr(5'h10, 8'hA5);
    wait_done();
    chk("R7 new start", starts - s0, 1);
    chk("R7 no stop between", stops - p0, 0);
    rd(5'h08, v); chk("R7 repeat bit self clears", v[2], 0);
    wr(5'h0C, 8'h00);

    // R5 reception
    wr(5'h08, 8'hE0);
    rd(5'h10, v);
    wait_done();
    chk("R5 master ack", mack, 0);
    wr(5'h0C, 8'h00);
    wr(5'h08, 8'hE8);
    rd(5'h10, v);
    chk("R5 first byte returned", v, 8'h5A);
    wait_done();
    chk("R5 master nack", mack, 1);
    wr(5'h0C, 8'h00);

    // R6 read in transmit mode clocks nothing
    wr(5'h08, 8'hF0);
    r0 = scl_rises;
    rd(5'h10, v);
    chk("R5 last byte returned", v, 8'hC3);
    repeat (200) @(negedge clk);
    chk("R6 no scl clock", scl_rises - r0, 0);
    rd(5'h0C, v); chk("R6 no completion", v[1], 0);

    // R8 STOP
    p0 = stops;
    wr(5'h08, 8'hC0);
    repeat (100) @(negedge clk);
    chk("R8 stop seen", stops - p0, 1);
    rd(5'h0C, v); chk("R8 bus idle", v[5], 0);
    chk("R8 lines released", {scl_w, sda_w}, 2'b11);

    // R9 clear and completion in the same cycle
    wr(5'h08, 8'hF0);
    repeat (40) @(negedge clk);
    wr(5'h10, 8'hA4);
    begin
      int hit = 0;
      @(negedge clk);
      reg_addr = 5'h0C; reg_wdata = 8'h00; reg_wr = 1'b1;
      for (int i = 0; i < 5000 && hit == 0; i++) begin
        @(negedge clk); #1;
        if (reg_rdata[7]) begin
          hit = 1;
          chk("R9 set wins over clear", reg_rdata[1], 1);
        end
      end
      reg_wr = 1'b0;
      chk("R9 completion reached", hit, 1);
    end
    wr(5'h0C, 8'h00);
    wr(5'h08, 8'hC0);
    repeat (100) @(negedge clk);

    // R11 arbitration loss
    wr(5'h08, 8'hF0);
    repeat (40) @(negedge clk);
    p0 = stops;
    wr(5'h10, 8'hFF);
    rival = 1'b1;
    wait_done();
    rd(5'h0C, v);
    chk("R11 arbitration flag", v[4], 1);
    chk("R11 no completion flag", v[7], 0);
    rd(5'h08, v); chk("R11 master bit cleared", v[5], 0);
    repeat (5) @(negedge clk);
    chk("R11 scl released", scl_w, 1);
    chk("R11 no stop driven", stops - p0, 0);
    rival = 1'b0;
    repeat (50) @(negedge clk);
    wr(5'h0C, 8'h00);
    rd(5'h0C, v); chk("R9 arbitration flag cleared", v[4], 0);

    // R12 low phase at divider 2
    wr(5'h04, 8'h02);
    wr(5'h08, 8'hF0);
    repeat (40) @(negedge clk);
    wr(5'h10, 8'h96);
    measure_low(len);
    chk("R12 low phase div2", len, 5);
    wait_done();
    chk("R3 byte at divider 2", rxq[$], 8'h96);
    wr(5'h0C, 8'h00);
    wr(5'h08, 8'hC0);
    repeat (60) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule